// File: doc/BRIEF.md
# Fixed-Head Disk Function and Status Register

This block holds the 18-bit function and status word of a head-per-track disk controller that sits on an 18-bit processor I/O bus. The processor issues I/O pulses. Three pulse lines pick an action group, and a two-bit selector picks the action inside that group. The block decodes these pulses to clear the flags, to test the flags for a skip, to clear the whole word, to read the word back onto the bus, and to load the word from the accumulator. The transfer engine reports its outcome through single-cycle event strobes: done, parity error, illegal address and not ready. These strobes set the matching flags.

After every update the block settles the word. The error summary bit is recomputed from the four error flags. A set done bit forces busy low. The low nine bits always read as zero. Every status load ends with a one-cycle strobe to the transfer engine: start when busy is left set, cancel when it is not. The interrupt request follows the settled word. Disk storage and data movement belong to the transfer engine and are outside this block.

All pins carry plain control and status. No data stream crosses the edge, so there is no valid/ready pair and no back-pressure. The engine must accept start and cancel in the cycle they are raised.

Top module: `hpt_status_reg`

## Requirements
- R1: A synchronous reset clears the status word to zero and drops the interrupt request. It also drops both the start and cancel strobes.
- R2: Bits 8 down to 0 of the status word always read as zero, even after a load with all-ones data.
- R3: On a status load (pulse bit 2, selector 2), the new word is the old word masked to interrupt enable (bit 11), busy (bit 10) and write (bit 9), XORed with the accumulator with its low nine bits cleared. The word is then settled as R4, R5 and R2 describe.
- R4: After every update, the error summary (bit 17) equals the OR of parity (bit 16), illegal address (bit 15), timing (bit 14) and not ready (bit 13). A value written directly into bit 17 is therefore replaced.
- R5: When done (bit 12) is set, busy (bit 10) is cleared in the same update.
- R6: The interrupt request is high exactly when interrupt enable is set and either error summary or done is set.
- R7: Clear-flags (pulse bit 0, selector 0) clears error summary, the four error flags and done. It leaves interrupt enable, busy and write unchanged.
- R8: Clear-all (pulse bit 0, selector 2) zeroes the whole word.
- R9: While skip-test (pulse bit 0, selector 1) is driven, the skip output is high exactly when error summary or done is set. Otherwise the skip output is low.
- R10: In the cycle after a status load, start pulses for one cycle if the settled word has busy set, and cancel pulses otherwise. Start and cancel stay low after any cycle without a load.
- R11: Event strobes set their flags: done sets bit 12, parity sets bit 16, illegal address sets bit 15 and not ready sets bit 13. An event in the same cycle as a clear wins, so its flag survives.
- R12: While read-status (pulse bit 1, selector 1) is driven, the read-data output carries the current word. At all other times it is zero.
- R13: When pulse bits 0 and 2 are both driven with selector 2, the clear-all takes effect first and the load is applied to the cleared word.
- R14: Selector 3 with any pulse bit has no effect. Pulse bit 1 with selectors 0 or 2 has no effect. Pulse bit 2 with selectors 0 or 1 has no effect. In each of these cases the word is unchanged and neither start nor cancel pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iop_i | input | 3 | I/O pulse lines, one bit per action group |
| sel_i | input | 2 | Selector for the action within a group |
| acc_i | input | 18 | Accumulator data for a status load |
| done_evt_i | input | 1 | Transfer engine finished |
| parity_evt_i | input | 1 | Transfer engine saw a parity error |
| badaddr_evt_i | input | 1 | Transfer engine saw an illegal address |
| notready_evt_i | input | 1 | Transfer engine found the drive not ready |
| status_o | output | 18 | Current status word, for the transfer engine |
| rdata_o | output | 18 | Bus read data, nonzero only during read-status |
| skip_o | output | 1 | Skip request during skip-test |
| start_o | output | 1 | One-cycle transfer start strobe |
| cancel_o | output | 1 | One-cycle transfer cancel strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. Each pulse and each event strobe lasts one clock cycle. The selector is stable while a pulse is high. The assertion on clear-all also takes no stimulus for granted, because it is gated off in any cycle that also carries a load or an event. The stimulus keeps within these limits: it drives each input set at the falling edge, holds it across exactly one rising edge, and returns every pulse and event to idle before the outputs are sampled.

// File: rtl/hpt_stat_pkg.sv
`timescale 1ns/1ps
package hpt_stat_pkg;
  localparam int WORD_W  = 18;
  localparam int LOW_W   = 9;
  localparam int PULSE_W = 3;
  localparam int SEL_W   = 2;

  // Bit positions of the status word (decoded by software, so fixed)
  localparam int B_ERR = 17;
  localparam int B_PAR = 16;
  localparam int B_ILA = 15;
  localparam int B_TIM = 14;
  localparam int B_NRY = 13;
  localparam int B_DON = 12;
  localparam int B_IE  = 11;
  localparam int B_BSY = 10;
  localparam int B_WR  = 9;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t ONE       = word_t'(1);
  localparam word_t LOW_MASK  = (ONE << LOW_W) - ONE;
  localparam word_t KEEP_MASK = (ONE << B_IE) | (ONE << B_BSY) | (ONE << B_WR);
  localparam word_t FLAG_MASK = (ONE << B_ERR) | (ONE << B_PAR) | (ONE << B_ILA)
                              | (ONE << B_TIM) | (ONE << B_NRY) | (ONE << B_DON);

  typedef struct packed {
    logic clr_flags;
    logic skip_test;
    logic clr_all;
    logic rd_stat;
    logic ld_stat;
  } cmd_t;

  typedef struct packed {
    logic done;
    logic parity;
    logic bad_addr;
    logic not_ready;
  } evt_t;

  // Derived-bit rules applied after any change to the word
  function automatic word_t settle(input word_t w);
    word_t r;
    r = w & ~LOW_MASK;
    r[B_ERR] = r[B_PAR] | r[B_ILA] | r[B_TIM] | r[B_NRY];
    if (r[B_DON]) r[B_BSY] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/hpt_pulse_decode.sv
`timescale 1ns/1ps
module hpt_pulse_decode
  import hpt_stat_pkg::*;
#(
  parameter int P_W = PULSE_W,
  parameter int S_W = SEL_W
) (
  input  logic [P_W-1:0] iop_i,
  input  logic [S_W-1:0] sel_i,
  output cmd_t           cmd_o
);
  localparam int G_FLAG = 0;   // flag group
  localparam int G_READ = 1;   // readback group
  localparam int G_LOAD = 2;   // load group
  localparam logic [S_W-1:0] SEL_A = S_W'(0);
  localparam logic [S_W-1:0] SEL_B = S_W'(1);
  localparam logic [S_W-1:0] SEL_C = S_W'(2);

  always_comb begin
    cmd_o           = '0;
    cmd_o.clr_flags = iop_i[G_FLAG] && (sel_i == SEL_A);
    cmd_o.skip_test = iop_i[G_FLAG] && (sel_i == SEL_B);
    cmd_o.clr_all   = iop_i[G_FLAG] && (sel_i == SEL_C);
    cmd_o.rd_stat   = iop_i[G_READ] && (sel_i == SEL_B);
    cmd_o.ld_stat   = iop_i[G_LOAD] && (sel_i == SEL_C);
  end
endmodule

// File: rtl/hpt_status_core.sv
`timescale 1ns/1ps
module hpt_status_core
  import hpt_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  cmd_t  cmd_i,
  input  word_t acc_i,
  input  evt_t  evt_i,
  output word_t stat_o,
  output logic  start_o,
  output logic  cancel_o
);
  word_t stat_q, step_clr, step_ld, step_evt, stat_d;
  logic  start_q, cancel_q;
  logic  any_evt;

  assign any_evt = evt_i.done | evt_i.parity | evt_i.bad_addr | evt_i.not_ready;

  always_comb begin
    // clears first, then the load, then engine events (events win)
    step_clr = stat_q;
    if (cmd_i.clr_all)   step_clr = '0;
    if (cmd_i.clr_flags) step_clr = step_clr & ~FLAG_MASK;

    step_ld = step_clr;
    if (cmd_i.ld_stat) step_ld = (step_clr & KEEP_MASK) ^ (acc_i & ~LOW_MASK);

    step_evt = step_ld;
    if (evt_i.done)      step_evt[B_DON] = 1'b1;
    if (evt_i.parity)    step_evt[B_PAR] = 1'b1;
    if (evt_i.bad_addr)  step_evt[B_ILA] = 1'b1;
    if (evt_i.not_ready) step_evt[B_NRY] = 1'b1;

    stat_d = settle(step_evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      start_q  <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      stat_q   <= stat_d;
      start_q  <= cmd_i.ld_stat &  stat_d[B_BSY];
      cancel_q <= cmd_i.ld_stat & ~stat_d[B_BSY];
    end
  end

  assign stat_o   = stat_q;
  assign start_o  = start_q;
  assign cancel_o = cancel_q;

  assert_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    stat_q[LOW_W-1:0] == '0);

  assert_summary_R4: assert property (@(posedge clk) disable iff (rst)
    stat_q[B_ERR] == (stat_q[B_PAR] | stat_q[B_ILA] | stat_q[B_TIM] | stat_q[B_NRY]));

  assert_done_busy_R5: assert property (@(posedge clk) disable iff (rst)
    !(stat_q[B_DON] && stat_q[B_BSY]));

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_i.clr_all && !cmd_i.ld_stat && !any_evt) |=> (stat_q == '0));

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_i.ld_stat |=> (start_q != cancel_q));

  assert_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_i.ld_stat |=> (!start_q && !cancel_q));

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (rst)
    start_q |-> stat_q[B_BSY]);

  assert_event_sticks_R11: assert property (@(posedge clk) disable iff (rst)
    evt_i.parity |=> stat_q[B_PAR]);
endmodule

// File: rtl/hpt_flag_outputs.sv
`timescale 1ns/1ps
module hpt_flag_outputs
  import hpt_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  cmd_t  cmd_i,
  input  word_t stat_i,
  output word_t rdata_o,
  output logic  skip_o,
  output logic  irq_o
);
  logic attention;

  assign attention = stat_i[B_ERR] | stat_i[B_DON];
  assign irq_o     = stat_i[B_IE] & attention;
  assign skip_o    = cmd_i.skip_test & attention;
  assign rdata_o   = cmd_i.rd_stat ? stat_i : '0;

  assert_irq_enable_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> stat_i[B_IE]);

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_i[B_IE] && stat_i[B_DON]) |-> irq_o);

  assert_skip_only_on_test_R9: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> cmd_i.skip_test);

  assert_quiet_bus_R12: assert property (@(posedge clk) disable iff (rst)
    !cmd_i.rd_stat |-> (rdata_o == '0));
endmodule

// File: rtl/hpt_status_reg.sv
`timescale 1ns/1ps
module hpt_status_reg
  import hpt_stat_pkg::*;
#(
  parameter int P_W = PULSE_W,
  parameter int S_W = SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [P_W-1:0]    iop_i,
  input  logic [S_W-1:0]    sel_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              done_evt_i,
  input  logic              parity_evt_i,
  input  logic              badaddr_evt_i,
  input  logic              notready_evt_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              skip_o,
  output logic              start_o,
  output logic              cancel_o,
  output logic              irq_o
);
  cmd_t  cmd;
  evt_t  evt;
  word_t stat;

  assign evt = '{done: done_evt_i, parity: parity_evt_i,
                 bad_addr: badaddr_evt_i, not_ready: notready_evt_i};

  hpt_pulse_decode #(.P_W(P_W), .S_W(S_W)) u_decode (
    .iop_i (iop_i),
    .sel_i (sel_i),
    .cmd_o (cmd)
  );

  hpt_status_core u_core (
    .clk      (clk),
    .rst      (rst),
    .cmd_i    (cmd),
    .acc_i    (acc_i),
    .evt_i    (evt),
    .stat_o   (stat),
    .start_o  (start_o),
    .cancel_o (cancel_o)
  );

  hpt_flag_outputs u_out (
    .clk     (clk),
    .rst     (rst),
    .cmd_i   (cmd),
    .stat_i  (stat),
    .rdata_o (rdata_o),
    .skip_o  (skip_o),
    .irq_o   (irq_o)
  );

  assign status_o = stat;
endmodule

// File: tb/test_hpt_status_reg.sv
`timescale 1ns/1ps
module test_hpt_status_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  iop = '0;
  logic [1:0]  sel = '0;
  logic [17:0] acc = '0;
  logic [3:0]  evt = '0;   // {done, parity, bad address, not ready}
  logic [17:0] status, rdata;
  logic        skip, start, cancel, irq;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  hpt_status_reg i_hpt_status_reg (
    .clk            (clk),
    .rst            (rst),
    .iop_i          (iop),
    .sel_i          (sel),
    .acc_i          (acc),
    .done_evt_i     (evt[3]),
    .parity_evt_i   (evt[2]),
    .badaddr_evt_i  (evt[1]),
    .notready_evt_i (evt[0]),
    .status_o       (status),
    .rdata_o        (rdata),
    .skip_o         (skip),
    .start_o        (start),
    .cancel_o       (cancel),
    .irq_o          (irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  iop;
    logic [1:0]  sel;
    logic [17:0] acc;
    logic [3:0]  evt;
    logic [17:0] exp_st;
    logic        exp_start;
    logic        exp_cancel;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  3'b100, 2'd2, 18'h00E00, 4'b0000, 18'h00E00, 1'b1, 1'b0, 1'b0}, // R3 set IE,BSY,WR
    '{4'd3,  3'b100, 2'd2, 18'h00400, 4'b0000, 18'h00A00, 1'b0, 1'b1, 1'b0}, // R3 XOR drops busy
    '{4'd10, 3'b100, 2'd2, 18'h00600, 4'b0000, 18'h00C00, 1'b1, 1'b0, 1'b0}, // R10 start
    '{4'd5,  3'b000, 2'd0, 18'h00000, 4'b1000, 18'h01800, 1'b0, 1'b0, 1'b1}, // R5 done clears busy
    '{4'd7,  3'b001, 2'd0, 18'h00000, 4'b0000, 18'h00800, 1'b0, 1'b0, 1'b0}, // R7 clear flags
    '{4'd4,  3'b000, 2'd0, 18'h00000, 4'b0100, 18'h30800, 1'b0, 1'b0, 1'b1}, // R4 parity sets summary
    '{4'd11, 3'b001, 2'd0, 18'h00000, 4'b0010, 18'h28800, 1'b0, 1'b0, 1'b1}, // R11 event beats clear
    '{4'd8,  3'b001, 2'd2, 18'h00000, 4'b0000, 18'h00000, 1'b0, 1'b0, 1'b0}, // R8 clear all
    '{4'd2,  3'b100, 2'd2, 18'h3FFFF, 4'b0000, 18'h3FA00, 1'b0, 1'b1, 1'b1}, // R2 low bits zero
    '{4'd3,  3'b100, 2'd2, 18'h00000, 4'b0000, 18'h00A00, 1'b0, 1'b1, 1'b0}, // R3 overwrite flags
    '{4'd4,  3'b100, 2'd2, 18'h24000, 4'b0000, 18'h24A00, 1'b0, 1'b1, 1'b1}, // R4 timing keeps summary
    '{4'd4,  3'b100, 2'd2, 18'h20000, 4'b0000, 18'h00A00, 1'b0, 1'b1, 1'b0}, // R4 summary recomputed
    '{4'd14, 3'b100, 2'd3, 18'h3FFFF, 4'b0000, 18'h00A00, 1'b0, 1'b0, 1'b0}, // R14 selector 3
    '{4'd14, 3'b010, 2'd2, 18'h3FFFF, 4'b0000, 18'h00A00, 1'b0, 1'b0, 1'b0}, // R14 unused code
    '{4'd13, 3'b101, 2'd2, 18'h00400, 4'b0000, 18'h00400, 1'b1, 1'b0, 1'b0}, // R13 clear then load
    '{4'd6,  3'b000, 2'd0, 18'h00000, 4'b0001, 18'h22400, 1'b0, 1'b0, 1'b0}, // R6 no IE, no irq
    '{4'd11, 3'b001, 2'd2, 18'h00000, 4'b1000, 18'h01000, 1'b0, 1'b0, 1'b0}  // R11 done beats clear all
  };

  task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] p, input logic [1:0] s,
                      input logic [17:0] a, input logic [3:0] e);
    @(negedge clk);
    iop = p; sel = s; acc = a; evt = e;
    @(negedge clk);
    iop = '0; sel = '0; acc = '0; evt = '0;
    #1;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 status", status, 18'h0);
    check("R1 irq", {17'h0, irq}, 18'h0);
    check("R1 start/cancel", {16'h0, start, cancel}, 18'h0);
    check("R12 idle rdata", rdata, 18'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].iop, VEC[i].sel, VEC[i].acc, VEC[i].evt);
      check($sformatf("R%0d vec%0d status", VEC[i].req, i), status, VEC[i].exp_st);
      check($sformatf("R%0d vec%0d start", VEC[i].req, i), {17'h0, start}, {17'h0, VEC[i].exp_start});
      check($sformatf("R%0d vec%0d cancel", VEC[i].req, i), {17'h0, cancel}, {17'h0, VEC[i].exp_cancel});
      check($sformatf("R%0d vec%0d irq", VEC[i].req, i), {17'h0, irq}, {17'h0, VEC[i].exp_irq});
    end

    // word is now 0x01000 (done only)
    @(negedge clk);
    check("R10 strobe gone", {16'h0, start, cancel}, 18'h0);
    iop = 3'b001; sel = 2'd1; #1;
    check("R9 skip on done", {17'h0, skip}, 18'h1);
    @(negedge clk);
    iop = 3'b010; sel = 2'd1; #1;
    check("R12 read status", rdata, 18'h01000);
    check("R9 no skip without test", {17'h0, skip}, 18'h0);
    @(negedge clk);
    iop = '0; sel = '0; #1;
    check("R12 rdata after read", rdata, 18'h0);

    step(3'b001, 2'd2, 18'h0, 4'b0000);   // clear all
    @(negedge clk);
    iop = 3'b001; sel = 2'd1; #1;
    check("R9 no skip when clear", {17'h0, skip}, 18'h0);
    @(negedge clk);
    iop = '0; sel = '0;

    // R1 reset while an interrupt is pending
    step(3'b100, 2'd2, 18'h04800, 4'b0000);  // timing + IE
    check("R1 irq before reset", {17'h0, irq}, 18'h1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 status after reset", status, 18'h0);
    check("R1 irq after reset", {17'h0, irq}, 18'h0);

    finished = 1;
    summary();
    $finish;
  end
endmodule